// File: doc/BRIEF.md
# Supply Channel Overload and Thermal Protection Controller

This block guards one supply output. It watches a current-overload indication and two temperature comparators: one that trips when the die is too hot and one that releases once it has cooled. From these it drives an output-enable and two diagnostic flags, one for overload and one for over-temperature. The current clamp and the temperature sensing are analog and sit outside the block. Only their digital indications arrive here. Those indications are asynchronous, so each one passes through a synchronizer first.

A mode input selects how an overload is handled. In dynamic (hiccup) mode, an overload turns the output off for a long off window. The output is then turned back on for a short trial window lasting one tenth as long. Normal operation returns only after a trial window that contains no overload. In static mode the output stays on and the overload flag simply mirrors the overload indication.

Thermal shutdown has hysteresis and always wins over the overload logic. All window lengths are parameters counted in clock cycles.

Top module: `supply_guard`

## Requirements
- R1: In dynamic mode (`static_mode_i` = 0) with the output running, a rise of `overload_i` drives `out_en_o` low and `ovl_flag_o` high on the third rising clock edge after the input changes. Two of those edges are spent in the synchronizer and one in the state register.
- R2: An off window keeps `out_en_o` low for exactly `OFF_CYCLES` cycles. It is followed by a trial window in which `out_en_o` is high for exactly `OFF_CYCLES/ON_DIV` cycles while `ovl_flag_o` stays high.
- R3: If the synchronized overload is seen in any cycle of a trial window, including its final cycle, a new off window follows that trial window.
- R4: A trial window with no overload seen returns the block to normal running, with `out_en_o` high and `ovl_flag_o` low, and `ovl_flag_o` then stays low.
- R5: In static mode (`static_mode_i` = 1) the timer never turns the output off. `ovl_flag_o` equals `overload_i` with a latency of three clock edges.
- R6: `temp_trip_i` = 1 sets `hot_flag_o` three edges later. `hot_flag_o` stays set while both comparator inputs are 0. It clears three edges after `temp_release_i` = 1 while `temp_trip_i` = 0. When both inputs are 1, the trip wins.
- R7: Switching `static_mode_i` from 1 to 0 while the synchronized overload is present starts an off window on the next rising edge.
- R8: While `rst_n` is low and after it is released, `out_en_o` = 1, `ovl_flag_o` = 0 and `hot_flag_o` = 0.
- R9: While `hot_flag_o` = 1, `out_en_o` = 0 whatever the overload state or mode. The overload flag keeps its own behaviour during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| static_mode_i | input | 1 | 1 = static flag-follow mode, 0 = dynamic hiccup mode (synchronous) |
| overload_i | input | 1 | Asynchronous overload (clamp active) indication |
| temp_trip_i | input | 1 | Asynchronous high-temperature trip comparator |
| temp_release_i | input | 1 | Asynchronous cool-down release comparator |
| out_en_o | output | 1 | Output enable for the supply stage |
| ovl_flag_o | output | 1 | Overload diagnostic flag |
| hot_flag_o | output | 1 | Over-temperature diagnostic flag |

## Verification
A table of steady input combinations covers static mode and the thermal hysteresis. It separates a flag that follows the overload from one that latches. It also separates the trip-only, release-only, in-between and both-asserted comparator states, and shows that heat forces the output off in every mode. Directed hiccup sequences then follow.

- A single overload followed by a clean trial measures both window lengths and the recovery.
- A persistent overload must produce a second off window.
- A one-cycle overload placed inside a trial window separates "overload seen anywhere in the window" from "overload present at its end".
- A mode switch with an overload held checks the one-cycle start.
- A reset during an off window checks the return to the reset state.

// File: rtl/sg_pkg.sv
package sg_pkg;

  typedef enum logic [1:0] {
    SG_RUN = 2'd0,
    SG_OFF = 2'd1,
    SG_TRY = 2'd2
  } sg_state_e;

endpackage

// File: rtl/sg_sync.sv
module sg_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] chain_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= '0;
          else        chain_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= '0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/sg_thermal.sv
module sg_thermal (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_i,
  input  logic release_i,
  output logic hot_o
);

  logic hot_q;
  logic hot_d;
  logic hot_upd;

  // The trip comparator has priority over the release comparator.
  always_comb begin
    hot_upd = trip_i | release_i;
    hot_d   = trip_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hot_q <= 1'b0;
    else if (hot_upd) hot_q <= hot_d;
  end

  assign hot_o = hot_q;

endmodule

// File: rtl/sg_hiccup.sv
module sg_hiccup
  import sg_pkg::*;
#(
  parameter int OFF_CYCLES = 90_000_000,
  parameter int ON_DIV     = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic static_mode_i,
  input  logic ovl_i,
  output logic tmr_en_o,
  output logic flag_o
);

  localparam int ON_RAW     = OFF_CYCLES / ON_DIV;
  localparam int ON_CYCLES  = (ON_RAW < 1) ? 1 : ON_RAW;
  localparam int CNT_W      = (OFF_CYCLES > 1) ? $clog2(OFF_CYCLES) : 1;
  localparam logic [CNT_W-1:0] OFF_LOAD = CNT_W'(OFF_CYCLES - 1);
  localparam logic [CNT_W-1:0] ON_LOAD  = CNT_W'(ON_CYCLES - 1);

  sg_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             fail_q, fail_d;
  logic             flag_q, flag_d;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    fail_d  = fail_q;
    flag_d  = flag_q;
    if (static_mode_i) begin
      // Flag follows the clamp; the timer is parked.
      state_d = SG_RUN;
      flag_d  = ovl_i;
      fail_d  = 1'b0;
    end else begin
      unique case (state_q)
        SG_RUN: begin
          if (ovl_i) begin
            state_d = SG_OFF;
            cnt_d   = OFF_LOAD;
            flag_d  = 1'b1;
          end else begin
            flag_d  = 1'b0;
          end
        end
        SG_OFF: begin
          flag_d = 1'b1;
          if (cnt_zero) begin
            state_d = SG_TRY;
            cnt_d   = ON_LOAD;
            fail_d  = 1'b0;
          end else begin
            cnt_d   = cnt_q - 1'b1;
          end
        end
        SG_TRY: begin
          flag_d = 1'b1;
          if (cnt_zero) begin
            if (fail_q | ovl_i) begin
              state_d = SG_OFF;
              cnt_d   = OFF_LOAD;
            end else begin
              state_d = SG_RUN;
              flag_d  = 1'b0;
            end
            fail_d = 1'b0;
          end else begin
            cnt_d  = cnt_q - 1'b1;
            fail_d = fail_q | ovl_i;
          end
        end
        default: begin
          state_d = SG_RUN;
          flag_d  = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SG_RUN;
      cnt_q   <= '0;
      fail_q  <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      fail_q  <= fail_d;
      flag_q  <= flag_d;
    end
  end

  assign tmr_en_o = (state_q != SG_OFF);
  assign flag_o   = flag_q;

endmodule

// File: rtl/supply_guard.sv
module supply_guard #(
  parameter int OFF_CYCLES  = 90_000_000,
  parameter int ON_DIV      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic static_mode_i,
  input  logic overload_i,
  input  logic temp_trip_i,
  input  logic temp_release_i,
  output logic out_en_o,
  output logic ovl_flag_o,
  output logic hot_flag_o
);

  localparam int N_ASYNC = 3;

  logic [N_ASYNC-1:0] raw_in;
  logic [N_ASYNC-1:0] syn_in;
  logic               ovl_s;
  logic               trip_s;
  logic               rel_s;
  logic               tmr_en;
  logic               hot;
  logic               flag;

  assign raw_in = {temp_release_i, temp_trip_i, overload_i};

  sg_sync #(
    .WIDTH  (N_ASYNC),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (raw_in),
    .sync_o  (syn_in)
  );

  assign ovl_s  = syn_in[0];
  assign trip_s = syn_in[1];
  assign rel_s  = syn_in[2];

  sg_hiccup #(
    .OFF_CYCLES (OFF_CYCLES),
    .ON_DIV     (ON_DIV)
  ) u_hiccup (
    .clk           (clk),
    .rst_n         (rst_n),
    .static_mode_i (static_mode_i),
    .ovl_i         (ovl_s),
    .tmr_en_o      (tmr_en),
    .flag_o        (flag)
  );

  sg_thermal u_thermal (
    .clk       (clk),
    .rst_n     (rst_n),
    .trip_i    (trip_s),
    .release_i (rel_s),
    .hot_o     (hot)
  );

  assign out_en_o   = tmr_en & ~hot;
  assign ovl_flag_o = flag;
  assign hot_flag_o = hot;

endmodule

// File: rtl/supply_guard_chk.sv
module supply_guard_chk #(
  parameter int OFF_CYCLES = 90_000_000
) (
  input logic clk,
  input logic rst_n,
  input logic static_mode,
  input logic ovl_s,
  input logic trip_s,
  input logic rel_s,
  input logic tmr_en,
  input logic out_en,
  input logic ovl_flag,
  input logic hot_flag
);

  logic [31:0] off_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       off_run_q <= '0;
    else if (!tmr_en) off_run_q <= off_run_q + 1'b1;
    else              off_run_q <= '0;
  end

  // R1: an output held off while not hot is always reported as overload
  p_off_has_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_en && !hot_flag) |-> ovl_flag);

  // R1: a fresh overload in dynamic mode raises the flag next cycle
  p_enter_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!static_mode && ovl_s && !ovl_flag) |=> ovl_flag);

  // R2: an off window never exceeds its length
  p_off_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    off_run_q <= 32'(OFF_CYCLES));

  // R5: static mode keeps the timer from cutting the output
  p_static_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (static_mode && $past(static_mode) && !hot_flag) |-> out_en);

  // R5: static flag tracks the synchronized overload
  p_static_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    static_mode |=> (ovl_flag == $past(ovl_s)));

  // R6: a synchronized trip always sets the thermal flag
  p_trip_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trip_s |=> hot_flag);

  // R6: without either comparator the thermal flag holds
  p_hot_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hot_flag && !trip_s && !rel_s) |=> hot_flag);

  // R9: heat forces the output off
  p_hot_kills_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hot_flag |-> !out_en);

endmodule

bind supply_guard supply_guard_chk #(
  .OFF_CYCLES (OFF_CYCLES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .static_mode (static_mode_i),
  .ovl_s       (ovl_s),
  .trip_s      (trip_s),
  .rel_s       (rel_s),
  .tmr_en      (tmr_en),
  .out_en      (out_en_o),
  .ovl_flag    (ovl_flag_o),
  .hot_flag    (hot_flag_o)
);

// File: tb/tb_supply_guard.sv
`timescale 1ns/1ps
module tb_supply_guard;

  localparam int OFF_C  = 40;
  localparam int ON_DV  = 10;
  localparam int ON_C   = OFF_C / ON_DV;
  localparam int N_VEC  = 12;
  localparam int WD_MAX = 150_000;

  logic clk;
  logic rst_n;
  logic static_mode;
  logic ovl;
  logic trip;
  logic rel;
  logic out_en;
  logic ovl_flag;
  logic hot_flag;

  int n_cmp;
  int n_bad;
  int cyc;
  bit done;

  // {static, ovl, trip, rel, exp_en, exp_olf, exp_otf}
  localparam logic [6:0] VEC [N_VEC] = '{
    7'b1_0_0_1_1_0_0,  // R5 static idle
    7'b1_1_0_1_1_1_0,  // R5 static overload: flag up, output kept
    7'b1_0_0_1_1_0_0,  // R5 flag drops with the overload
    7'b1_0_1_0_0_0_1,  // R6 trip
    7'b1_0_0_0_0_0_1,  // R6 between thresholds: held
    7'b1_0_0_1_1_0_0,  // R6 release
    7'b1_1_1_0_0_1_1,  // R9 heat and overload together
    7'b1_1_0_0_0_1_1,  // R9 still hot, overload flag kept
    7'b1_0_0_0_0_0_1,  // R6 overload gone, still hot
    7'b1_0_1_1_0_0_1,  // R6 both comparators: trip wins
    7'b1_0_0_1_1_0_0,  // R6 release alone clears
    7'b0_0_0_1_1_0_0   // R4 dynamic, no overload
  };

  supply_guard #(
    .OFF_CYCLES  (OFF_C),
    .ON_DIV      (ON_DV),
    .SYNC_STAGES (2)
  ) dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .static_mode_i  (static_mode),
    .overload_i     (ovl),
    .temp_trip_i    (trip),
    .temp_release_i (rel),
    .out_en_o       (out_en),
    .ovl_flag_o     (ovl_flag),
    .hot_flag_o     (hot_flag)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > WD_MAX) begin
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WD_MAX);
        finish_run();
      end
    end
  end

  task automatic chk3(string req, logic [2:0] exp);
    logic [2:0] act;
    act = {out_en, ovl_flag, hot_flag};
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual en/olf/otf=%b expected %b", req, act, exp);
    end
  endtask

  task automatic chk_int(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Wait on negedges until out_en equals v, at most lim cycles.
  task automatic wait_en(logic v, int lim);
    for (int k = 0; k < lim; k++) begin
      if (out_en === v) return;
      @(negedge clk);
    end
  endtask

  initial begin
    int cnt;
    n_cmp = 0;
    n_bad = 0;
    done  = 1'b0;
    rst_n = 1'b0;
    static_mode = 1'b1;
    ovl  = 1'b0;
    trip = 1'b0;
    rel  = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk3("R8 in reset", 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk3("R8 after reset", 3'b100);

    // Vector table
    for (int i = 0; i < N_VEC; i++) begin
      @(negedge clk);
      {static_mode, ovl, trip, rel} = VEC[i][6:3];
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk3($sformatf("R5/R6/R9 vector %0d", i), VEC[i][2:0]);
    end

    // R1 latency, R2 window lengths, R4 recovery
    ovl = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk3("R1 not yet after two edges", 3'b100);
    @(posedge clk);
    @(negedge clk);
    chk3("R1 off after third edge", 3'b010);
    ovl = 1'b0;
    cnt = 0;
    while (out_en === 1'b0 && cnt < 1000) begin
      cnt++;
      @(negedge clk);
    end
    chk_int("R2 off window length", cnt, OFF_C);
    cnt = 0;
    while (out_en === 1'b1 && ovl_flag === 1'b1 && cnt < 1000) begin
      cnt++;
      @(negedge clk);
    end
    chk_int("R2 trial window length", cnt, ON_C);
    chk3("R4 clean trial resumes", 3'b100);
    repeat (5) @(negedge clk);
    chk3("R4 flag stays low", 3'b100);

    // R3 persistent overload
    ovl = 1'b1;
    wait_en(1'b0, 20);
    wait_en(1'b1, 100);
    cnt = 0;
    while (out_en === 1'b1 && cnt < 100) begin
      cnt++;
      @(negedge clk);
    end
    chk_int("R3 trial length before retry", cnt, ON_C);
    chk3("R3 second off window", 3'b010);
    ovl = 1'b0;
    wait_en(1'b1, 100);
    repeat (ON_C + 1) @(negedge clk);
    chk3("R4 recovery after persistent overload", 3'b100);

    // R3 one-cycle overload inside a trial window
    ovl = 1'b1;
    @(negedge clk);
    ovl = 1'b0;
    wait_en(1'b0, 20);
    wait_en(1'b1, 100);
    ovl = 1'b1;
    @(negedge clk);
    ovl = 1'b0;
    wait_en(1'b0, 10);
    chk3("R3 short overload in trial fails it", 3'b010);
    wait_en(1'b1, 100);
    repeat (ON_C + 1) @(negedge clk);
    chk3("R4 recovery after short overload", 3'b100);

    // R7 mode switch with overload present
    static_mode = 1'b1;
    ovl = 1'b1;
    repeat (5) @(negedge clk);
    chk3("R5 static with overload held", 3'b110);
    static_mode = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk3("R7 off window one clock after switch", 3'b010);

    // R8 reset during an off window
    ovl = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk3("R8 reset during off window", 3'b100);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk3("R8 running after reset", 3'b100);

    finish_run();
  end

endmodule